// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block inspects the first six bytes of each received Ethernet frame, which hold the destination address, and decides whether the frame is kept. The address arrives one byte per strobe. The first byte of a frame carries a start marker. One clock after the sixth byte, the block raises a decision flag and an accept bit. Both stay stable until the next frame begins.

A frame is accepted in four cases:
- the promiscuous control bit is set;
- the destination is the all-ones broadcast address;
- the destination equals the programmed station address;
- the destination is a group address whose multicast bin is marked in a 256-bin table.

The bin is the top byte of the bit-reversed reflected CRC-32 of the six address bytes. The block computes it on the fly as the bytes stream in.

Software programs the block through a plain write port:
- the station address, held in two words;
- the promiscuous bit;
- the eight 32-bit table words.

Separate join and leave commands set or clear a single bin without a read-modify-write.

Top module: `rx_dest_filter`

## Requirements
- R1: The multicast bin is computed with the reflected CRC-32 polynomial 0xEDB88320. The register starts at all ones. The six address bytes are fed in arrival order, each least-significant bit first. The 32-bit result is fully bit-reversed with no final inversion, and its upper 8 bits form the bin.
- R2: The table is eight 32-bit words, written at config addresses 8 to 15. Bin bits [7:5] select the word and bin bits [4:0] select the bit. Bits are numbered MSB-first, so bin n lives in word n/32 at bit position 31-(n mod 32).
- R3: A join command sets the addressed table bit and a leave command clears it, starting from the next cycle. If a config write hits the same word in the same cycle, the command still decides its own bit.
- R4: After reset, the following are all zero: every table word, both station words, the promiscuous bit, the decision flag and the accept bit.
- R5: The station address is programmed in two config words:
  - Config address 0 holds address bytes 5, 4, 3, 2 from bit 31 down to bit 0.
  - Config address 1 holds byte 1 in bits [31:24] and byte 0 in bits [23:16]; its lower half is ignored.
  - Byte 0 is the first byte received.
  - A destination equal to this address is accepted.
- R6: When bit 0 of config address 2 (promiscuous) is 1, every frame is accepted.
- R7: The table lookup applies only when bit 0 of the first address byte is 1. A unicast destination whose bin is marked is rejected unless another rule accepts it.
- R8: The all-ones broadcast destination is always accepted.
- R9: The decision flag and the accept bit change one clock after the sixth address byte is taken. Before that the flag stays 0. Bytes after the sixth, up to the next start marker, leave both unchanged.
- R10: A strobed byte carrying the start marker begins a new frame as address byte 0 and drops the decision flag at the next edge. Strobed bytes before the first start marker are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_vld | input | 1 | Receive byte strobe |
| rx_sof | input | 1 | Start marker, qualified by rx_vld |
| rx_byte | input | 8 | Receive byte |
| cfg_we | input | 1 | Config write enable |
| cfg_addr | input | 4 | Config word address |
| cfg_wdata | input | 32 | Config write data |
| mc_cmd_vld | input | 1 | Join/leave command strobe |
| mc_cmd_join | input | 1 | 1 = join (set bin), 0 = leave (clear bin) |
| mc_cmd_bin | input | 8 | Bin addressed by the command |
| decision_vld | output | 1 | Decision for current frame is available |
| accept | output | 1 | Frame accepted |

## Verification
The in-RTL properties check a set of rules on every cycle:
- the decision flag rises only after a sixth byte and falls on a start marker;
- the accept bit holds while the decision is valid;
- promiscuous and broadcast frames are always accepted, and a unicast frame that misses the station address is always rejected;
- a join or leave leaves its bin in the commanded state;
- the CRC state holds between strobes.

Other behaviour can only be shown by the bench's scenarios, where an independent bit-serial CRC model predicts each bin:
- whether the hash, the MSB-first table layout and the station byte order are correct;
- the priority between a word write and a same-cycle command;
- the treatment of bytes outside the address window.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int MAC_BYTES = 6;
  localparam int TBL_REGS  = 8;
  localparam int TBL_W     = 32;
  localparam int BIN_W     = $clog2(TBL_REGS * TBL_W);
  localparam logic [31:0] CRC_POLY = 32'hEDB88320;
  localparam logic [31:0] CRC_SEED = 32'hFFFFFFFF;

  // One byte of reflected CRC-32, LSB of the byte first.
  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'h0, b};
    for (int k = 0; k < 8; k++)
      r = (r >> 1) ^ (r[0] ? CRC_POLY : 32'h0);
    return r;
  endfunction

  // Bit-reverse the CRC and keep its top BIN_W bits.
  function automatic logic [BIN_W-1:0] crc_bin(input logic [31:0] c);
    logic [31:0] rv;
    for (int k = 0; k < 32; k++)
      rv[k] = c[31-k];
    return rv[31 -: BIN_W];
  endfunction
endpackage

// File: rtl/rxf_crc_hash.sv
module rxf_crc_hash
  import rxf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             first,
  input  logic [7:0]       byte_in,
  output logic [BIN_W-1:0] bin_now
);
  logic [31:0] crc_q;
  logic [31:0] crc_base;
  logic [31:0] crc_nx;

  assign crc_base = first ? CRC_SEED : crc_q;
  assign crc_nx   = crc_step(crc_base, byte_in);
  assign bin_now  = crc_bin(crc_nx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    crc_q <= CRC_SEED;
    else if (take) crc_q <= crc_nx;
  end

  // R1: running CRC only advances on a taken address byte
  p_crc_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(crc_q));
endmodule

// File: rtl/rxf_hash_table.sv
module rxf_hash_table
  import rxf_pkg::*;
#(
  parameter int NREG  = TBL_REGS,
  parameter int WW    = TBL_W,
  localparam int NBIN  = NREG * WW,
  localparam int BW    = $clog2(NBIN),
  localparam int SEL_W = $clog2(NREG),
  localparam int POS_W = $clog2(WW)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [WW-1:0]    wr_data,
  input  logic             cmd_vld,
  input  logic             cmd_join,
  input  logic [BW-1:0]    cmd_bin,
  input  logic [BW-1:0]    look_bin,
  output logic             look_hit
);
  logic [WW-1:0]    tbl_q [NREG];
  logic [NBIN-1:0]  flat;
  logic [SEL_W-1:0] cmd_sel;
  logic [POS_W-1:0] cmd_pos;

  assign cmd_sel = cmd_bin[BW-1 -: SEL_W];
  assign cmd_pos = ~cmd_bin[POS_W-1:0];   // MSB-first numbering

  for (genvar r = 0; r < NREG; r++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tbl_q[r] <= '0;
      end else begin
        if (wr_en && wr_sel == SEL_W'(r))
          tbl_q[r] <= wr_data;
        if (cmd_vld && cmd_sel == SEL_W'(r))
          tbl_q[r][cmd_pos] <= cmd_join;
      end
    end
  end

  for (genvar n = 0; n < NBIN; n++) begin : g_flat
    assign flat[n] = tbl_q[n / WW][WW - 1 - (n % WW)];
  end

  assign look_hit = flat[look_bin];

  // R3: join leaves the bin set
  p_join_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld && cmd_join |=> flat[$past(cmd_bin)]);
  // R3: leave leaves the bin clear
  p_leave_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld && !cmd_join |=> !flat[$past(cmd_bin)]);
  // R2: without write or command the table holds
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en && !cmd_vld |=> $stable(flat));
endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
  import rxf_pkg::*;
#(
  parameter int CFG_AW = 4,
  localparam int SEL_W = $clog2(TBL_REGS),
  localparam int CNT_W = $clog2(MAC_BYTES + 1),
  localparam int HOLD_BYTES = MAC_BYTES - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_vld,
  input  logic              rx_sof,
  input  logic [7:0]        rx_byte,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              mc_cmd_vld,
  input  logic              mc_cmd_join,
  input  logic [BIN_W-1:0]  mc_cmd_bin,
  output logic              decision_vld,
  output logic              accept
);
  localparam logic [CFG_AW-1:0] A_STA_HI = CFG_AW'(0);
  localparam logic [CFG_AW-1:0] A_STA_LO = CFG_AW'(1);
  localparam logic [CFG_AW-1:0] A_CTRL   = CFG_AW'(2);

  // configuration
  logic [31:0] sta_hi_q;
  logic [15:0] sta_lo_q;
  logic        promisc_q;
  logic        tbl_we;

  assign tbl_we = cfg_we && cfg_addr[CFG_AW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sta_hi_q  <= '0;
      sta_lo_q  <= '0;
      promisc_q <= 1'b0;
    end else if (cfg_we) begin
      if (cfg_addr == A_STA_HI) sta_hi_q  <= cfg_wdata;
      if (cfg_addr == A_STA_LO) sta_lo_q  <= cfg_wdata[31:16];
      if (cfg_addr == A_CTRL)   promisc_q <= cfg_wdata[0];
    end
  end

  // address byte tracking
  logic [CNT_W-1:0]          cnt_q;
  logic [CNT_W-1:0]          pos;
  logic                      take;
  logic                      sixth_evt;
  logic                      sof_evt;
  logic [HOLD_BYTES*8-1:0]   addr_q;

  assign sof_evt   = rx_vld && rx_sof;
  assign take      = sof_evt ||
                     (rx_vld && cnt_q != '0 && cnt_q < CNT_W'(MAC_BYTES));
  assign pos       = rx_sof ? '0 : cnt_q;
  assign sixth_evt = take && pos == CNT_W'(MAC_BYTES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      addr_q <= '0;
    end else if (take) begin
      cnt_q <= pos + CNT_W'(1);
      for (int k = 0; k < HOLD_BYTES; k++)
        if (pos == CNT_W'(k)) addr_q[k*8 +: 8] <= rx_byte;
    end
  end

  // hash path
  logic [BIN_W-1:0] bin_now;
  logic             tbl_hit;

  rxf_crc_hash u_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .first   (sof_evt),
    .byte_in (rx_byte),
    .bin_now (bin_now)
  );

  rxf_hash_table u_tbl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (tbl_we),
    .wr_sel   (cfg_addr[SEL_W-1:0]),
    .wr_data  (cfg_wdata),
    .cmd_vld  (mc_cmd_vld),
    .cmd_join (mc_cmd_join),
    .cmd_bin  (mc_cmd_bin),
    .look_bin (bin_now),
    .look_hit (tbl_hit)
  );

  // decision
  logic [8*MAC_BYTES-1:0] dest;
  logic [8*MAC_BYTES-1:0] station;
  logic is_group, is_bcast, is_station, verdict;

  assign dest       = {rx_byte, addr_q};          // byte 5 on top, byte 0 at bottom
  assign station    = {sta_hi_q, sta_lo_q};
  assign is_group   = addr_q[0];
  assign is_bcast   = &dest;
  assign is_station = dest == station;
  assign verdict    = promisc_q || is_bcast || is_station || (is_group && tbl_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      decision_vld <= 1'b0;
      accept       <= 1'b0;
    end else if (sixth_evt) begin
      decision_vld <= 1'b1;
      accept       <= verdict;
    end else if (sof_evt) begin
      decision_vld <= 1'b0;
      accept       <= 1'b0;
    end
  end

  // R9: decision only appears right after a sixth byte
  p_vld_after_sixth_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(decision_vld) |-> $past(sixth_evt));
  // R9: decision holds until the next start marker
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    decision_vld && !sof_evt |=> decision_vld && $stable(accept));
  // R10: start marker drops the decision
  p_sof_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sof_evt |=> !decision_vld);
  // R6: promiscuous accepts everything
  p_promisc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sixth_evt && promisc_q |=> accept);
  // R8: broadcast always accepted
  p_bcast_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sixth_evt && is_bcast |=> accept);
  // R7: unicast that misses the station is rejected
  p_unicast_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sixth_evt && !is_group && !is_station && !promisc_q |=> !accept);
endmodule

// File: tb/rx_dest_filter_tb.sv
module rx_dest_filter_tb;
  localparam logic [31:0] POLY = 32'hEDB88320;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_vld = 1'b0, rx_sof = 1'b0;
  logic [7:0]  rx_byte = 8'h0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = 4'h0;
  logic [31:0] cfg_wdata = 32'h0;
  logic        mc_cmd_vld = 1'b0, mc_cmd_join = 1'b0;
  logic [7:0]  mc_cmd_bin = 8'h0;
  logic        decision_vld, accept;

  always #10 clk = ~clk;   // 50 MHz

  rx_dest_filter u_dut (
    .clk(clk), .rst_n(rst_n), .rx_vld(rx_vld), .rx_sof(rx_sof), .rx_byte(rx_byte),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .mc_cmd_vld(mc_cmd_vld), .mc_cmd_join(mc_cmd_join), .mc_cmd_bin(mc_cmd_bin),
    .decision_vld(decision_vld), .accept(accept)
  );

  int n_chk = 0, n_bad = 0;
  logic [31:0] sh [8];
  logic [47:0] sta;       // byte 0 at [47:40]
  logic        prom;

  task automatic check(input string req, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b", req, got, exp);
    end
  endtask

  function automatic logic [7:0] ref_bin(input logic [47:0] a);
    logic [31:0] c = 32'hFFFFFFFF;
    logic [31:0] rv;
    for (int i = 0; i < 6; i++)
      for (int b = 0; b < 8; b++) begin
        logic fb;
        fb = c[0] ^ a[40 - 8*i + b];
        c = {1'b0, c[31:1]} ^ (fb ? POLY : 32'h0);
      end
    for (int k = 0; k < 32; k++) rv[31-k] = c[k];
    return rv[31:24];
  endfunction

  function automatic logic model(input logic [47:0] a);
    logic [7:0] bn;
    bn = ref_bin(a);
    return prom || (a == 48'hFFFF_FFFF_FFFF) || (a == sta) ||
           (a[40] && sh[bn[7:5]][31 - bn[4:0]]);
  endfunction

  task automatic cfg_write(input logic [3:0] ad, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = ad; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (ad >= 4'd8) sh[ad[2:0]] = d;
    if (ad == 4'd0) sta[31:0] = {d[7:0], d[15:8], d[23:16], d[31:24]};
    if (ad == 4'd1) sta[47:32] = {d[23:16], d[31:24]};
    if (ad == 4'd2) prom = d[0];
  endtask

  task automatic mc_cmd(input logic j, input logic [7:0] bn);
    @(negedge clk);
    mc_cmd_vld = 1'b1; mc_cmd_join = j; mc_cmd_bin = bn;
    @(negedge clk);
    mc_cmd_vld = 1'b0;
    sh[bn[7:5]][31 - bn[4:0]] = j;
  endtask

  // send a destination address plus payload bytes, check decision timing and value
  task automatic send(input string req, input logic [47:0] a, input int npay);
    logic exp, acc0;
    exp = model(a);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (i == 5) check("R9 no early decision", decision_vld, 1'b0);
      rx_vld = 1'b1; rx_sof = (i == 0); rx_byte = a[47 - 8*i -: 8];
    end
    @(negedge clk);
    rx_vld = 1'b0; rx_sof = 1'b0;
    check("R9 decision valid", decision_vld, 1'b1);
    check(req, accept, exp);
    acc0 = accept;
    if (npay > 0) begin
      for (int i = 0; i < npay; i++) begin
        @(negedge clk);
        rx_vld = 1'b1; rx_byte = 8'hFF - 8'(i);
      end
      @(negedge clk);
      rx_vld = 1'b0;
      check("R9 hold over payload", accept, acc0);
      check("R9 hold vld", decision_vld, 1'b1);
    end
  endtask

  localparam logic [48:0] VEC [12] = '{
    {48'h02_1A_2B_3C_4D_5E, 1'b0},
    {48'h02_1A_2B_3C_4D_5F, 1'b0},
    {48'hFF_FF_FF_FF_FF_FF, 1'b0},
    {48'h01_00_5E_00_00_01, 1'b0},
    {48'h33_33_00_00_00_01, 1'b0},
    {48'h01_00_5E_7F_FF_FA, 1'b0},
    {48'h00_11_22_33_44_55, 1'b0},
    {48'h00_11_22_33_44_55, 1'b1},
    {48'h01_80_C2_00_00_0E, 1'b1},
    {48'hFF_FF_FF_FF_FF_FE, 1'b0},
    {48'h03_1A_2B_3C_4D_5E, 1'b0},
    {48'hAB_CD_EF_01_23_45, 1'b0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [47:0] u;
    logic [7:0]  bn;
    for (int r = 0; r < 8; r++) sh[r] = '0;
    sta = '0; prom = 1'b0;
    repeat (3) @(negedge clk);
    check("R4 reset vld", decision_vld, 1'b0);
    check("R4 reset accept", accept, 1'b0);
    rst_n = 1'b1;

    // R10: bytes before any start marker are ignored
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); rx_vld = 1'b1; rx_byte = 8'hFF;
    end
    @(negedge clk); rx_vld = 1'b0;
    check("R10 ignored before sof", decision_vld, 1'b0);

    // R4: empty table, zero station
    send("R4 group rejected with empty table", 48'h01_00_5E_00_00_01, 0);
    send("R4 zero station matches zero address", 48'h0, 0);

    // R5 station programming, lower half of word 1 ignored
    cfg_write(4'd0, 32'h5E4D_3C2B);
    cfg_write(4'd1, 32'h1A02_BEEF);
    mc_cmd(1'b1, ref_bin(48'h01_00_5E_00_00_01));
    mc_cmd(1'b1, ref_bin(48'h33_33_00_00_00_01));

    foreach (VEC[v]) begin
      cfg_write(4'd2, {31'h0, VEC[v][0]});
      send("R1 R5 R6 R8 vector", VEC[v][48:1], v % 3);
    end
    cfg_write(4'd2, 32'h0);

    // R7: unicast whose bin is marked is still rejected
    u = 48'h00_AA_BB_CC_DD_EE;
    mc_cmd(1'b1, ref_bin(u));
    send("R7 unicast ignores table", u, 0);

    // R2: direct word write, MSB-first bit position
    u = 48'h01_12_34_56_78_9A;
    bn = ref_bin(u);
    cfg_write({1'b1, bn[7:5]}, 32'h1 << bn[4:0]);
    send("R2 mirrored bit misses", u, 0);
    cfg_write({1'b1, bn[7:5]}, 32'h8000_0000 >> bn[4:0]);
    send("R2 msb-first bit hits", u, 1);

    // R3: leave clears; command beats same-cycle write
    mc_cmd(1'b0, bn);
    send("R3 leave clears", u, 0);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = {1'b1, bn[7:5]}; cfg_wdata = 32'h0;
    mc_cmd_vld = 1'b1; mc_cmd_join = 1'b1; mc_cmd_bin = bn;
    @(negedge clk);
    cfg_we = 1'b0; mc_cmd_vld = 1'b0;
    sh[bn[7:5]] = '0; sh[bn[7:5]][31 - bn[4:0]] = 1'b1;
    send("R3 join wins over write", u, 0);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = {1'b1, bn[7:5]}; cfg_wdata = 32'hFFFF_FFFF;
    mc_cmd_vld = 1'b1; mc_cmd_join = 1'b0; mc_cmd_bin = bn;
    @(negedge clk);
    cfg_we = 1'b0; mc_cmd_vld = 1'b0;
    sh[bn[7:5]] = 32'hFFFF_FFFF; sh[bn[7:5]][31 - bn[4:0]] = 1'b0;
    send("R3 leave wins over write", u, 0);

    // R10: start marker drops the decision at the next edge
    @(negedge clk); rx_vld = 1'b1; rx_sof = 1'b1; rx_byte = 8'hFF;
    @(negedge clk); rx_vld = 1'b0; rx_sof = 1'b0;
    check("R10 sof clears decision", decision_vld, 1'b0);
    // R10: restart mid-address, then full broadcast accepted
    send("R8 R10 broadcast after restart", 48'hFF_FF_FF_FF_FF_FF, 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule